// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block restarts a stalled system in two steps. A down-counter runs on a slow tick-enable input, one tick per 10 ms, so a reload value from 1 to 9990 gives a timeout from 0.01 s to 99.9 s. Each register access by software restarts the count from the programmed reload value. A program that keeps running therefore holds the counter away from zero.

When no access arrives before the count runs out, the block raises a halt request. This asks the processor to enter its firmware halt handler and save its state. A fixed grace interval of ticks follows, and then the block drives a module reset pulse of a fixed number of clock cycles. At the start of that pulse it sets a sticky reset-reason flag. Reset code reads the flag to tell that the watchdog caused the restart. After the pulse, the counter is armed again with the programmed reload value.

Top module: `wdog_two_stage`

## Requirements
- R1: After a synchronous reset, `halt_req`, `mod_rst` and `reason` are 0 and the reload value is `RELOAD_DEFAULT` (9990 by default).
- R2: While armed, the counter moves only on cycles with `tick` = 1. `halt_req` rises in the clock after the N-th tick without an access, where N is the reload value.
- R3: In the armed state, `reg_acc` = 1 restarts the full count of N ticks. A tick in the same cycle as the access is not counted.
- R4: In the armed state, `load_we` = 1 stores `load_data` as the new reload value and restarts the count from it. A value of 0 is stored as 1, and a value above `MAX_LOAD` (9990) is stored as `MAX_LOAD`.
- R5: `halt_req` stays high for exactly `GRACE_TICKS` (30) ticks. In the clock after the last of these ticks, `halt_req` falls and `mod_rst` rises.
- R6: During the grace interval and during the reset pulse, `reg_acc` and `load_we` are ignored. They neither cancel the pending reset nor change the reload value.
- R7: `mod_rst` stays high for exactly `RST_CYCLES` (16) clocks whatever `tick` does. After that, the block is armed with a full count of the stored reload value.
- R8: `reason` becomes 1 in the same clock as `mod_rst` rises. It stays 1 until `reason_clr` = 1 clears it in the next clock. It is not cleared by the block's own reset pulse. If a set and a clear happen in the same cycle, the set wins.
- R9: `halt_req` and `mod_rst` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-resolution enable, one pulse per 10 ms |
| reg_acc | input | 1 | Register access strobe, restarts the count |
| load_we | input | 1 | Write strobe for the reload value (also an access) |
| load_data | input | CNT_W | Reload value in ticks |
| reason_clr | input | 1 | Clears the sticky reset-reason flag |
| halt_req | output | 1 | Request to enter the firmware halt handler |
| mod_rst | output | 1 | Module hardware reset pulse |
| reason | output | 1 | Sticky flag: the last reset was caused by the watchdog |

## Verification
All three outputs are registered, so each one answers in the clock that follows the edge sampling the stimulus. This holds for the expiring tick, for the last grace tick, for the last pulse cycle and for a clear strobe. The bench drives inputs 1 ns after a rising edge and reads the outputs 1 ns after the next rising edge. It then compares them with a cycle model advanced by one step per edge. Directed runs count ticks up to the exact expiry and count the clocks of the reset pulse. Random traffic is compared against the same model on every cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WD_ARMED = 2'd0,
    WD_GRACE = 2'd1,
    WD_PULSE = 2'd2
  } wd_state_e;
endpackage

// File: rtl/wdog_load_clamp.sv
module wdog_load_clamp #(
  parameter int CNT_W    = 14,
  parameter int MAX_LOAD = 9990
) (
  input  logic [CNT_W-1:0] raw,
  output logic [CNT_W-1:0] limited
);
  localparam logic [CNT_W-1:0] LIM_HI = CNT_W'(MAX_LOAD);
  localparam logic [CNT_W-1:0] LIM_LO = CNT_W'(1);

  always_comb begin
    if (raw == '0)          limited = LIM_LO;
    else if (raw > LIM_HI)  limited = LIM_HI;
    else                    limited = raw;
  end
endmodule

// File: rtl/wdog_dcount.sv
module wdog_dcount #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         last
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= W'(RST_VAL);
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - W'(1);
  end

  assign last = (cnt == W'(1));

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    !(dec && !load && cnt == '0)); // R7
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int CNT_W          = 14,
  parameter int MAX_LOAD       = 9990,
  parameter int RELOAD_DEFAULT = 9990,
  parameter int GRACE_TICKS    = 30,
  parameter int RST_CYCLES     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             reg_acc,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_data,
  input  logic             reason_clr,
  output logic             halt_req,
  output logic             mod_rst,
  output logic             reason
);
  import wdog_pkg::*;

  localparam int GR_W = $clog2(GRACE_TICKS + 1);
  localparam int PL_W = $clog2(RST_CYCLES + 1);

  wd_state_e        state_q, state_d;
  logic [CNT_W-1:0] reload_q, clamped, main_cnt, main_val;
  logic [GR_W-1:0]  grace_cnt;
  logic [PL_W-1:0]  pulse_cnt;
  logic             main_last, grace_last, pulse_last;
  logic             armed, in_grace, in_pulse, touched;
  logic             main_load, main_dec, expire;
  logic             grace_load, grace_dec, enter_pulse;
  logic             pulse_dec, leave_pulse;

  assign armed    = (state_q == WD_ARMED);
  assign in_grace = (state_q == WD_GRACE);
  assign in_pulse = (state_q == WD_PULSE);
  assign touched  = reg_acc | load_we;

  wdog_load_clamp #(.CNT_W(CNT_W), .MAX_LOAD(MAX_LOAD)) u_clamp (
    .raw(load_data), .limited(clamped)
  );

  // reload value register: writable only while armed
  always_ff @(posedge clk) begin
    if (rst)                  reload_q <= CNT_W'(RELOAD_DEFAULT);
    else if (armed && load_we) reload_q <= clamped;
  end

  // stage one: timeout counter
  assign expire      = armed && !touched && tick && main_last;
  assign leave_pulse = in_pulse && pulse_last;
  assign main_load   = (armed && touched) || leave_pulse;
  assign main_val    = (armed && load_we) ? clamped : reload_q;
  assign main_dec    = armed && !touched && tick && !main_last;

  wdog_dcount #(.W(CNT_W), .RST_VAL(RELOAD_DEFAULT)) u_main (
    .clk(clk), .rst(rst), .load(main_load), .load_val(main_val),
    .dec(main_dec), .cnt(main_cnt), .last(main_last)
  );

  // stage two: grace interval in ticks
  assign enter_pulse = in_grace && tick && grace_last;
  assign grace_load  = expire;
  assign grace_dec   = in_grace && tick && !grace_last;

  wdog_dcount #(.W(GR_W), .RST_VAL(0)) u_grace (
    .clk(clk), .rst(rst), .load(grace_load), .load_val(GR_W'(GRACE_TICKS)),
    .dec(grace_dec), .cnt(grace_cnt), .last(grace_last)
  );

  // reset pulse width in clocks
  assign pulse_dec = in_pulse && !pulse_last;

  wdog_dcount #(.W(PL_W), .RST_VAL(0)) u_pulse (
    .clk(clk), .rst(rst), .load(enter_pulse), .load_val(PL_W'(RST_CYCLES)),
    .dec(pulse_dec), .cnt(pulse_cnt), .last(pulse_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WD_ARMED: if (expire)      state_d = WD_GRACE;
      WD_GRACE: if (enter_pulse) state_d = WD_PULSE;
      WD_PULSE: if (leave_pulse) state_d = WD_ARMED;
      default:                   state_d = WD_ARMED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= WD_ARMED;
      halt_req <= 1'b0;
      mod_rst  <= 1'b0;
    end else begin
      state_q  <= state_d;
      halt_req <= (state_d == WD_GRACE);
      mod_rst  <= (state_d == WD_PULSE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              reason <= 1'b0;
    else if (enter_pulse) reason <= 1'b1;
    else if (reason_clr)  reason <= 1'b0;
  end

  AST_HALT_FROM_LAST_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(halt_req) |-> ($past(main_cnt) == CNT_W'(1) && $past(tick))); // R2
  AST_ARMED_RANGE: assert property (@(posedge clk) disable iff (rst)
    armed |-> (main_cnt >= CNT_W'(1) && main_cnt <= CNT_W'(MAX_LOAD))); // R4
  AST_RELOAD_RANGE: assert property (@(posedge clk) disable iff (rst)
    (reload_q >= CNT_W'(1) && reload_q <= CNT_W'(MAX_LOAD))); // R4
  AST_HALT_LEADS_RESET: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_rst) |-> $past(halt_req)); // R5
  AST_GRACE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (halt_req && !tick) |=> halt_req); // R6
  AST_GRACE_KEEPS_RELOAD: assert property (@(posedge clk) disable iff (rst)
    halt_req |=> $stable(reload_q)); // R6
  AST_PULSE_IGNORES_TICK: assert property (@(posedge clk) disable iff (rst)
    (mod_rst && pulse_cnt > PL_W'(1)) |=> mod_rst); // R7
  AST_REASON_WITH_RESET: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_rst) |-> reason); // R8
  AST_REASON_STICKY: assert property (@(posedge clk) disable iff (rst)
    (reason && !reason_clr) |=> reason); // R8
  AST_OUTPUTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(halt_req && mod_rst)); // R9
endmodule

// File: tb/wdog_two_stage_bench.sv
`timescale 1ns/1ps
module wdog_two_stage_bench;
  localparam int CNT_W = 14;
  localparam int MAXL  = 9990;
  localparam int GRACE = 30;
  localparam int PULSE = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, reg_acc = 1'b0, load_we = 1'b0, reason_clr = 1'b0;
  logic [CNT_W-1:0] load_data = '0;
  logic halt_req, mod_rst, reason;

  int errors = 0;
  int checks = 0;

  // reference model state: 0 armed, 1 grace, 2 pulse
  int m_st, m_cnt, m_rel, m_gr, m_pl;
  logic m_reason;

  always #2.5 clk = ~clk;

  wdog_two_stage u_wdog_two_stage (
    .clk(clk), .rst(rst), .tick(tick), .reg_acc(reg_acc), .load_we(load_we),
    .load_data(load_data), .reason_clr(reason_clr),
    .halt_req(halt_req), .mod_rst(mod_rst), .reason(reason)
  );

  function automatic int clamp_load(int v);
    if (v == 0) return 1;
    if (v > MAXL) return MAXL;
    return v;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_cnt = MAXL; m_rel = MAXL; m_gr = 0; m_pl = 0; m_reason = 1'b0;
  endtask

  task automatic model_step(logic a, logic w, int d, logic t, logic c);
    if (m_st == 1 && t && m_gr == 1) m_reason = 1'b1;
    else if (c) m_reason = 1'b0;
    case (m_st)
      0: begin
        if (w) begin m_rel = clamp_load(d); m_cnt = m_rel; end
        else if (a) m_cnt = m_rel;
        else if (t) begin
          if (m_cnt == 1) begin m_st = 1; m_gr = GRACE; end
          else m_cnt--;
        end
      end
      1: if (t) begin
        if (m_gr == 1) begin m_st = 2; m_pl = PULSE; end
        else m_gr--;
      end
      default: begin
        if (m_pl == 1) begin m_st = 0; m_cnt = m_rel; end
        else m_pl--;
      end
    endcase
  endtask

  // one clock: drive, wait edge, advance model, compare every output
  task automatic cyc(logic a, logic w, int d, logic t, logic c);
    reg_acc = a; load_we = w; load_data = CNT_W'(d); tick = t; reason_clr = c;
    @(posedge clk); #1;
    model_step(a, w, d, t, c);
    chk("R2 halt_req vs model", halt_req, m_st == 1);
    chk("R7 mod_rst vs model", mod_rst, m_st == 2);
    chk("R8 reason vs model", reason, m_reason);
    chk("R9 exclusive outputs", halt_req & mod_rst, 1'b0);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 0, 1'b1, 1'b0);
  endtask

  task automatic finish_pulse();
    int guard = 0;
    while ((halt_req || mod_rst) && guard < 200) begin
      ticks(1); guard++;
    end
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int hi_cnt;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk("R1 halt_req after reset", halt_req, 1'b0);
    chk("R1 mod_rst after reset", mod_rst, 1'b0);
    chk("R1 reason after reset", reason, 1'b0);

    // R1/R2: default reload expires on exactly the 9990th tick
    ticks(MAXL - 1);
    chk("R1 no halt at 9989 ticks", halt_req, 1'b0);
    ticks(1);
    chk("R2 halt at 9990 ticks", halt_req, 1'b1);

    // R6: accesses and writes during grace ignored
    for (int i = 0; i < GRACE - 1; i++) cyc(1'b1, 1'b1, 5, 1'b1, 1'b0);
    chk("R6 halt survives accesses", halt_req, 1'b1);
    chk("R5 no reset before last grace tick", mod_rst, 1'b0);
    cyc(1'b0, 1'b0, 0, 1'b1, 1'b1); // R8: clear in the set cycle loses
    chk("R5 reset after grace", mod_rst, 1'b1);
    chk("R5 halt dropped", halt_req, 1'b0);
    chk("R8 reason set wins", reason, 1'b1);

    // R7: pulse width with ticks and writes applied
    hi_cnt = 1;
    while (mod_rst && hi_cnt < 100) begin
      cyc(1'b1, 1'b1, 3, 1'b1, 1'b0);
      if (mod_rst) hi_cnt++;
    end
    checks++;
    if (hi_cnt != PULSE) begin
      errors++;
      $display("FAIL R7 pulse width: actual=%0d expected=%0d", hi_cnt, PULSE);
    end
    chk("R8 reason kept after pulse", reason, 1'b1);
    ticks(5);
    chk("R6 reload kept at default", halt_req, 1'b0);
    cyc(1'b0, 1'b0, 0, 1'b0, 1'b1);
    chk("R8 reason cleared", reason, 1'b0);

    // R3: access restarts, same-cycle tick not counted
    cyc(1'b0, 1'b1, 10, 1'b0, 1'b0);
    ticks(9);
    cyc(1'b1, 1'b0, 0, 1'b1, 1'b0);
    ticks(9);
    chk("R3 no halt 9 ticks after access", halt_req, 1'b0);
    ticks(1);
    chk("R3 halt 10 ticks after access", halt_req, 1'b1);
    finish_pulse();

    // R4: zero stored as one
    cyc(1'b0, 1'b1, 0, 1'b1, 1'b0);
    chk("R4 write with tick does not expire", halt_req, 1'b0);
    ticks(1);
    chk("R4 zero clamps to one", halt_req, 1'b1);
    finish_pulse();

    // R4: oversize value clamps to maximum
    cyc(1'b0, 1'b1, 16383, 1'b0, 1'b0);
    ticks(MAXL - 1);
    chk("R4 no halt at max-1", halt_req, 1'b0);
    ticks(1);
    chk("R4 halt at clamped max", halt_req, 1'b1);
    finish_pulse();

    // R2: idle cycles without tick do not count
    cyc(1'b0, 1'b1, 4, 1'b0, 1'b0);
    for (int i = 0; i < 50; i++) cyc(1'b0, 1'b0, 0, 1'b0, 1'b0);
    ticks(3);
    chk("R2 no count without tick", halt_req, 1'b0);
    ticks(1);
    chk("R2 halt after 4 ticks", halt_req, 1'b1);
    finish_pulse();

    // random traffic compared to the model
    void'($urandom(32'd1234));
    for (int i = 0; i < 20000; i++) begin
      logic a, w, t, c;
      int d;
      a = ($urandom % 40) == 0;
      w = ($urandom % 60) == 0;
      t = ($urandom % 3) != 0;
      c = ($urandom % 50) == 0;
      d = (($urandom % 20) == 0) ? int'($urandom % 16384) : int'($urandom % 24);
      cyc(a, w, d, t, c);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule